// File: doc/BRIEF.md
# Programmable Integer Clock Divider

This block divides an input clock by any integer ratio from 8 to 511. The ratio comes from a 9-bit control word. Every output period spans exactly that many input cycles. The high time of the output does not aim for half the period. It follows a fixed rule tied to the power-of-two band that the ratio falls in, so powers of two give an even duty cycle and other ratios give a shorter high time.

The divided signal leaves through a final flip-flop clocked straight from the input clock, which keeps counter delay out of the output edges. A phase-select input picks the edge this retiming stage uses. When it is 0 the stage uses the rising edge. When it is 1 it uses the falling edge, which moves every output transition half an input cycle earlier. Both the ratio and the phase select are taken only when a new output period begins, so a change never produces a shortened or stretched period.

Top module: `prog_clk_divider`

## Requirements
- R1: The ratio N is the unsigned value of `mod_word`, with bit 8 as the most significant bit. For every N from 8 to 511, consecutive rising edges of `clk_out` lie exactly N input cycles apart.
- R2: For N of 16 or more, `clk_out` stays high for half of the largest power of two that does not exceed N. For example, N = 100 gives 32 cycles high and N = 300 gives 128.
- R3: For N from 8 to 11, `clk_out` stays high for N−4 input cycles.
- R4: For N from 12 to 15, `clk_out` stays high for N−8 input cycles.
- R5: A `mod_word` value below 8, including 0, behaves as N = 8 with 4 cycles high.
- R6: With `phase_sel` at 0, `clk_out` changes only just after rising edges of `clk_in`. Its value is the same a quarter cycle and three quarters of a cycle after each rising edge.
- R7: With `phase_sel` at 1, `clk_out` changes only just after falling edges of `clk_in`, half a cycle earlier than with 0. Each output period then contains exactly two rising-edge cycles in which the value read a quarter cycle after the rising edge differs from the value read three quarters of a cycle after it.
- R8: New `mod_word` and `phase_sel` values take effect only at the start of an output period. The period in progress completes with its old ratio, high time and phase.
- R9: `rst` is synchronous and active high. While it is high, `clk_out` is low. Take the first rising edge of `clk_in` that samples `rst` low. With `phase_sel` at 0, `clk_out` goes high at the next rising edge after that one. With `phase_sel` at 1, it goes high at the falling edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| mod_word | input | 9 | Division ratio, unsigned, bit 8 is the MSB |
| phase_sel | input | 1 | Retiming edge: 0 rising, 1 falling |
| clk_out | output | 1 | Divided clock |

## Verification
A counter that skips or repeats a state shows up within one output period, as a rising-edge spacing that differs from N. A wrongly decoded high time shows up at the very next falling edge of `clk_out`. If the ratio or phase select is loaded in the middle of a period, the period in which the change was made is visibly too long or too short. A retiming stage on the wrong edge shows as a value that differs between the quarter-cycle and three-quarter-cycle samples, visible at the first transition of `clk_out`.

// File: rtl/prog_clk_divider.sv
module prog_clk_divider #(
  parameter int MOD_W = 9
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic [MOD_W-1:0] mod_word,
  input  logic             phase_sel,
  output logic             clk_out
);
  localparam int MIN_MOD = 8;
  localparam logic [MOD_W-1:0] MIN_N = MOD_W'(MIN_MOD);
  localparam logic [MOD_W-1:0] ONE   = MOD_W'(1);

  function automatic logic [MOD_W-1:0] high_len(input logic [MOD_W-1:0] n);
    logic [MOD_W-1:0] w;
    w = '0;
    if (n < MOD_W'(12))
      w = n - MOD_W'(4);
    else if (n < MOD_W'(16))
      w = n - MOD_W'(8);
    else
      for (int b = 4; b < MOD_W; b++)
        if (n[b]) w = ONE << (b - 1);
    return w;
  endfunction

  logic [MOD_W-1:0] cnt, cur_n, cur_w, eff_n;
  logic             run, cur_sel, q_p, q_n, raw, last;

  assign eff_n = (mod_word < MIN_N) ? MIN_N : mod_word;
  assign last  = (cnt == cur_n - ONE);
  assign raw   = run && (cnt < cur_w);

  always_ff @(posedge clk_in) begin
    if (rst) begin
      run     <= 1'b0;
      cnt     <= '0;
      cur_n   <= MIN_N;
      cur_w   <= high_len(MIN_N);
      cur_sel <= 1'b0;
      q_p     <= 1'b0;
    end else begin
      q_p <= raw;
      if (!run || last) begin
        run     <= 1'b1;
        cnt     <= '0;
        cur_n   <= eff_n;
        cur_w   <= high_len(eff_n);
        cur_sel <= phase_sel;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  always_ff @(negedge clk_in) begin
    if (rst) q_n <= 1'b0;
    else     q_n <= raw;
  end

  assign clk_out = cur_sel ? q_n : q_p;
endmodule

module prog_clk_divider_chk #(
  parameter int MOD_W = 9
) (
  input logic             clk_in,
  input logic             rst,
  input logic             clk_out,
  input logic             q_p,
  input logic             run,
  input logic [MOD_W-1:0] cnt,
  input logic [MOD_W-1:0] cur_n,
  input logic [MOD_W-1:0] cur_w,
  input logic             cur_sel
);
  int hi_len;

  always_ff @(posedge clk_in) begin
    if (rst || !q_p) hi_len <= 0;
    else             hi_len <= hi_len + 1;
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk_in) disable iff (rst)
    run |-> (cnt < cur_n));

  // R5
  n_floor_chk: assert property (@(posedge clk_in) disable iff (rst)
    cur_n >= MOD_W'(8));

  // R2 R3 R4
  high_len_chk: assert property (@(posedge clk_in) disable iff (rst)
    $fell(q_p) |-> (hi_len == int'(cur_w)));

  // R6
  rise_align_chk: assert property (@(posedge clk_in) disable iff (rst)
    $rose(q_p) |-> (cnt == MOD_W'(1)));

  // R8
  load_edge_chk: assert property (@(posedge clk_in) disable iff (rst)
    (run && cnt != '0) |-> ($stable(cur_n) && $stable(cur_w) && $stable(cur_sel)));

  // R9
  reset_low_chk: assert property (@(posedge clk_in)
    rst |=> !clk_out);
endmodule

bind prog_clk_divider prog_clk_divider_chk #(.MOD_W(MOD_W)) chk_i (
  .clk_in(clk_in), .rst(rst), .clk_out(clk_out), .q_p(q_p), .run(run),
  .cnt(cnt), .cur_n(cur_n), .cur_w(cur_w), .cur_sel(cur_sel)
);

// File: tb/prog_clk_divider_tb.sv
module prog_clk_divider_tb_top;
  localparam int CLK_P = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] mod_word = '0;
  logic       phase_sel = 1'b0;
  logic       clk_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  prog_clk_divider dut_i (
    .clk_in(clk), .rst(rst), .mod_word(mod_word),
    .phase_sel(phase_sel), .clk_out(clk_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_n(input int w);
    return (w < 8) ? 8 : w;
  endfunction

  function automatic int exp_hi(input int n);
    int p;
    if (n < 12) return n - 4;
    if (n < 16) return n - 8;
    p = 1;
    while (p * 2 <= n) p = p * 2;
    return p / 2;
  endfunction

  task automatic step();
    @(posedge clk);
    #(CLK_P*3/4);
  endtask

  task automatic wait_rise();
    logic prev;
    prev = clk_out;
    for (int i = 0; i < 2000; i++) begin
      step();
      if (!prev && clk_out) return;
      prev = clk_out;
    end
  endtask

  task automatic measure(output int hi, output int per);
    hi = 1; per = 1;
    step();
    for (int i = 0; i < 2000 && clk_out; i++) begin hi++; per++; step(); end
    for (int i = 0; i < 2000 && !clk_out; i++) begin per++; step(); end
  endtask

  task automatic probe(input int cycles, output int diffs, output int changes);
    logic a, b, prev;
    diffs = 0; changes = 0; prev = clk_out;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      #(CLK_P/4) a = clk_out;
      #(CLK_P/2) b = clk_out;
      if (a != b) diffs++;
      if (b != prev) changes++;
      prev = b;
    end
  endtask

  task automatic t_reset();
    int hi, per;
    rst = 1'b1; mod_word = 9'd10; phase_sel = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(clk_out == 1'b0, "R9 low in reset", clk_out, 0);
    end
    rst = 1'b0;
    step();
    chk(clk_out == 1'b0, "R9 first cycle after release", clk_out, 0);
    step();
    chk(clk_out == 1'b1, "R9 first high", clk_out, 1);
    measure(hi, per);
    chk(hi == 6, "R3 first pulse width N=10", hi, 6);
    chk(per == 10, "R1 first period N=10", per, 10);
  endtask

  task automatic t_ratio(input int w, input string tag_n, input string tag_w);
    int hi, per;
    mod_word = 9'(w);
    wait_rise();
    for (int k = 0; k < 2; k++) begin
      measure(hi, per);
      chk(per == exp_n(w), tag_n, per, exp_n(w));
      chk(hi == exp_hi(exp_n(w)), tag_w, hi, exp_hi(exp_n(w)));
    end
  endtask

  task automatic t_midchange();
    int hi, per;
    mod_word = 9'd20;
    wait_rise();
    mod_word = 9'd40;
    measure(hi, per);
    chk(per == 20, "R8 old period kept", per, 20);
    chk(hi == 8, "R8 old width kept", hi, 8);
    measure(hi, per);
    chk(per == 40, "R8 new period", per, 40);
    chk(hi == 16, "R8 new width", hi, 16);
  endtask

  task automatic t_phase();
    int d, c;
    phase_sel = 1'b0; mod_word = 9'd12;
    wait_rise(); wait_rise();
    probe(36, d, c);
    chk(d == 0, "R6 rising-edge retime diffs", d, 0);
    chk(c == 6, "R6 transitions seen", c, 6);
    wait_rise();
    phase_sel = 1'b1;
    probe(10, d, c);
    chk(d == 0, "R8 phase held mid-period", d, 0);
    probe(24, d, c);
    chk(d == 4, "R7 falling-edge retime diffs", d, 4);
    probe(36, d, c);
    chk(d == 6, "R7 steady diffs", d, 6);
    phase_sel = 1'b0;
  endtask

  task automatic t_reset_phase1();
    logic a;
    rst = 1'b1; phase_sel = 1'b1; mod_word = 9'd8;
    step(); step();
    rst = 1'b0;
    @(posedge clk);
    #(CLK_P/4) a = clk_out;
    chk(a == 1'b0, "R9 phase1 low before falling edge", a, 0);
    #(CLK_P/2);
    chk(clk_out == 1'b1, "R9 phase1 high after falling edge", clk_out, 1);
    phase_sel = 1'b0;
  endtask

  initial begin
    t_reset();
    t_ratio(0,   "R5 period word=0", "R5 width word=0");
    t_ratio(5,   "R5 period word=5", "R5 width word=5");
    t_ratio(8,   "R1 period N=8",    "R3 width N=8");
    t_ratio(9,   "R1 period N=9",    "R3 width N=9");
    t_ratio(11,  "R1 period N=11",   "R3 width N=11");
    t_ratio(12,  "R1 period N=12",   "R4 width N=12");
    t_ratio(15,  "R1 period N=15",   "R4 width N=15");
    t_ratio(16,  "R1 period N=16",   "R2 width N=16");
    t_ratio(23,  "R1 period N=23",   "R2 width N=23");
    t_ratio(31,  "R1 period N=31",   "R2 width N=31");
    t_ratio(32,  "R1 period N=32",   "R2 width N=32");
    t_ratio(100, "R1 period N=100",  "R2 width N=100");
    t_ratio(128, "R1 period N=128",  "R2 width N=128");
    t_ratio(255, "R1 period N=255",  "R2 width N=255");
    t_ratio(256, "R1 period N=256",  "R2 width N=256");
    t_ratio(300, "R1 period N=300",  "R2 width N=300");
    t_ratio(511, "R1 period N=511",  "R2 width N=511");
    t_midchange();
    t_phase();
    t_reset_phase1();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P*150000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule